// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block lets a downstream interrupt controller that only understands active-high levels and rising edges serve interrupts from a large bank of GPIO pads. It has eight output channels. Each channel picks one pad through a programmable index. The chosen pad is resynchronised into the local clock and cleaned by an optional glitch filter. It then passes through a trigger conditioner. The conditioner can present a level, invert it, turn a rising or falling transition into a one-clock pulse, or turn every transition into a one-clock pulse.

Software programs the block through a small word-addressed register port. A write is a full 32-bit word with a write strobe. Reads return the addressed register combinationally. There are four words: trigger control, pad indices for the lower four channels, pad indices for the upper four channels, and the filter lengths.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero and every output is low, so each channel is a non-inverted level channel on pad 0 with no filtering.
- R2: Word 0 is the trigger control, word 1 holds the pad indices of channels 0 to 3, word 2 holds those of channels 4 to 7, and word 3 holds the filter lengths; each word reads back what was last written to it.
- R3: Bits 31:24 of the trigger-control word always read as zero and ignore written values.
- R4: Channel n takes its 8-bit pad index from bits (n mod 4)*8+7 : (n mod 4)*8 of word 1 for n<4 and of word 2 for n>=4.
- R5: With trigger bits clear and filter length 0, a channel's output is high exactly while its pad is high, three clock edges after the pad changes.
- R6: Trigger-control bit 16+n inverts channel n, so in level mode the output is high while the pad is low.
- R7: Trigger-control bit n selects edge mode: one single-clock pulse per rising transition, or per falling transition when bit 16+n is also set, and nothing on the opposite transition.
- R8: Trigger-control bit 8+n gives a single-clock pulse on every transition of the pad and overrides bits n and 16+n.
- R9: A 4-bit filter length F at bits 4n+3 : 4n of word 3 requires a new pad value to persist for 2F clocks before it is used; shorter pulses never reach the output, and a held change reaches it 3+2F edges after the pad moves.
- R10: A filter length of 0 bypasses the filter for that channel regardless of the other channels' lengths.
- R11: A pad index at or above the number of implemented pads selects a constant zero input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pads | input | NUM_PADS | Asynchronous GPIO pad inputs |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_word | input | 2 | Word index (0 trigger, 1 and 2 pad indices, 3 filter) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| irq_out | output | 8 | Active-high interrupt per channel |

## Verification
The same channel can have its edge bit, its invert bit and its both-edge bit set at once, so all three trigger rules act on the same pad transition in the same cycle. The bench sets all three together and counts the pulses after one rising and one falling transition: exactly one pulse each shows that the override wins. The filter expiry and the edge detector also meet in one cycle, because the clean value moves on the same edge the counter saturates. The bench judges this by the exact edge on which the level output appears after a held change and by the absence of any output after a shorter glitch.

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router #(
  parameter int NUM_PADS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  logic                reg_we,
  input  logic [1:0]          reg_word,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [7:0]          irq_out
);
  localparam int NCH      = 8;
  localparam int SEL_W    = 8;
  localparam int FLT_W    = 4;
  localparam int CNT_W    = FLT_W + 1;
  localparam int PAD_SPAN = 1 << SEL_W;

  logic [23:0]         trig_q;
  logic [31:0]         sel_lo_q, sel_hi_q, flt_q;
  logic [PAD_SPAN-1:0] pad_ext;

  always_comb begin
    pad_ext = '0;
    pad_ext[NUM_PADS-1:0] = pads;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      flt_q    <= '0;
    end else if (reg_we) begin
      case (reg_word)
        2'd0: trig_q   <= reg_wdata[23:0];
        2'd1: sel_lo_q <= reg_wdata;
        2'd2: sel_hi_q <= reg_wdata;
        default: flt_q <= reg_wdata;
      endcase
    end
  end

  always_comb begin
    case (reg_word)
      2'd0: reg_rdata = {8'h00, trig_q};
      2'd1: reg_rdata = sel_lo_q;
      2'd2: reg_rdata = sel_hi_q;
      default: reg_rdata = flt_q;
    endcase
  end

  p_trig_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word == 2'd0) |-> (reg_rdata[31:24] == 8'h00));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int SOFF = (n % 4) * SEL_W;
    logic [SEL_W-1:0] sel;
    logic [FLT_W-1:0] fval;
    logic [CNT_W-1:0] cnt_q;
    logic edge_en, both_en, inv_en;
    logic s1_q, s2_q, filt_q, prev_q, irq_q;
    logic clean, nxt;

    assign sel     = (n < 4) ? sel_lo_q[SOFF +: SEL_W] : sel_hi_q[SOFF +: SEL_W];
    assign fval    = flt_q[n*FLT_W +: FLT_W];
    assign edge_en = trig_q[n];
    assign both_en = trig_q[8+n];
    assign inv_en  = trig_q[16+n];
    assign clean   = (fval == '0) ? s2_q : filt_q;

    always_comb begin
      if (both_en)      nxt = clean ^ prev_q;
      else if (edge_en) nxt = (clean ^ inv_en) & ~(prev_q ^ inv_en);
      else              nxt = clean ^ inv_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        filt_q <= 1'b0;
        cnt_q  <= '0;
        prev_q <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        s1_q   <= pad_ext[sel];
        s2_q   <= s1_q;
        prev_q <= clean;
        irq_q  <= nxt;
        if (fval == '0) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else if (s2_q == filt_q) begin
          cnt_q  <= '0;
        end else if (cnt_q + 1'b1 >= {fval, 1'b0}) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end

    assign irq_out[n] = irq_q;

    p_oob_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(int'(sel) >= NUM_PADS) |-> !s1_q);

    p_filter_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fval) != '0 && filt_q != $past(filt_q)) |-> ($past(s2_q) != $past(filt_q)));

    p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && !both_en && $past(edge_en && !both_en) && $stable(inv_en) && $past(irq_q))
        |-> !irq_q);
  end
endmodule

// File: tb/gpio_irq_router_tb.sv
`timescale 1ns/1ps
module gpio_irq_router_tb;
  localparam int NP = 200;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [NP-1:0] pads = '0;
  logic [1:0] reg_word = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [7:0] irq_out;
  int total = 0, bad = 0, pc;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_router #(.NUM_PADS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pads(pads), .reg_we(reg_we), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  localparam logic [65:0] VEC [6] = '{
    {2'd0, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {2'd1, 32'h1234_5678, 32'h1234_5678},
    {2'd2, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {2'd3, 32'h8765_4321, 32'h8765_4321},
    {2'd0, 32'hAB0F_00F0, 32'h000F_00F0},
    {2'd1, 32'h0000_0000, 32'h0000_0000}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_word = w; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    reg_word = w; #1; d = reg_rdata;
  endtask

  task automatic count(input int ch, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq_out[ch]) c++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pads = '0; reg_we = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      rd(w[1:0], rv);
      chk("R1 reset register", rv, 32'h0);
    end
    chk("R1 reset outputs", {24'h0, irq_out}, 32'h0);

    // R2 R3 table of writes and readbacks
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][65:64], rv);
      chk(VEC[i][65:64] == 2'd0 ? "R3 trigger readback" : "R2 readback", rv, VEC[i][31:0]);
    end

    // R5 level, channel 2 on pad 17
    do_reset();
    wr(2'd1, 32'h0011_0000);
    pads[17] = 1'b1;
    wait_n(2); chk("R5 before latency", {31'h0, irq_out[2]}, 32'h0);
    wait_n(1); chk("R5 level high", {24'h0, irq_out}, 32'h04);
    count(2, 5, pc); chk("R5 level held", pc, 5);
    pads[17] = 1'b0;
    wait_n(3); chk("R5 level low", {31'h0, irq_out[2]}, 32'h0);

    // R6 inverted level
    pads[17] = 1'b1;
    wr(2'd0, 32'h0004_0000);
    wait_n(4); chk("R6 inverted high pad", {31'h0, irq_out[2]}, 32'h0);
    pads[17] = 1'b0;
    wait_n(2); chk("R6 before latency", {31'h0, irq_out[2]}, 32'h0);
    wait_n(1); chk("R6 inverted low pad", {31'h0, irq_out[2]}, 32'h1);

    // R7 rising edge
    wr(2'd0, 32'h0000_0004);
    wait_n(5);
    pads[17] = 1'b1;
    wait_n(2); chk("R7 rise before", {31'h0, irq_out[2]}, 32'h0);
    wait_n(1); chk("R7 rise pulse", {31'h0, irq_out[2]}, 32'h1);
    wait_n(1); chk("R7 pulse one clock", {31'h0, irq_out[2]}, 32'h0);
    pads[17] = 1'b0;
    count(2, 8, pc); chk("R7 no pulse on fall", pc, 0);

    // R7 falling edge via inversion
    pads[17] = 1'b1;
    wr(2'd0, 32'h0004_0004);
    wait_n(5);
    pads[17] = 1'b0;
    count(2, 8, pc); chk("R7 falling pulse count", pc, 1);
    pads[17] = 1'b1;
    count(2, 8, pc); chk("R7 inverted no pulse on rise", pc, 0);

    // R8 both edges, overriding edge and invert
    wr(2'd0, 32'h0004_0404);
    wait_n(4);
    pads[17] = 1'b0;
    count(2, 8, pc); chk("R8 override fall", pc, 1);
    pads[17] = 1'b1;
    count(2, 8, pc); chk("R8 override rise", pc, 1);
    wr(2'd0, 32'h0000_0400);
    count(2, 10, pc); chk("R8 steady no pulse", pc, 0);
    pads[17] = 1'b0;
    count(2, 8, pc); chk("R8 both alone fall", pc, 1);

    // R9 filter length 3 on channel 2 (6 clocks)
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0000_0300);
    wait_n(4);
    pads[17] = 1'b1;
    wait_n(4);
    pads[17] = 1'b0;
    count(2, 20, pc); chk("R9 glitch rejected", pc, 0);
    pads[17] = 1'b1;
    wait_n(8); chk("R9 before filter expiry", {31'h0, irq_out[2]}, 32'h0);
    wait_n(1); chk("R9 after filter expiry", {31'h0, irq_out[2]}, 32'h1);

    // R10 bypass on channel 2 while neighbours filter
    wr(2'd3, 32'h0000_F0F0);
    pads[17] = 1'b0;
    wait_n(6);
    pads[17] = 1'b1;
    wait_n(2); chk("R10 bypass before", {31'h0, irq_out[2]}, 32'h0);
    wait_n(1); chk("R10 bypass latency", {31'h0, irq_out[2]}, 32'h1);

    // R4 field positions
    do_reset();
    wr(2'd2, 32'h0064_0000);
    pads[100] = 1'b1;
    wait_n(3); chk("R4 channel 6 field", {24'h0, irq_out}, 32'h40);
    wr(2'd1, 32'h2D00_0000);
    pads[45] = 1'b1;
    wait_n(3); chk("R4 channel 3 field", {24'h0, irq_out}, 32'h48);

    // R11 out-of-range index
    do_reset();
    wr(2'd2, 32'h0000_FA00);
    pads = '1;
    count(5, 10, pc); chk("R11 out of range low", pc, 0);
    wr(2'd0, 32'h0020_0000);
    wait_n(3); chk("R11 constant zero inverted", {31'h0, irq_out[5]}, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule